// File: doc/BRIEF.md
# GPIO Port Register Block with Atomic Bit Operations

This block is the register front end of one general-purpose I/O port whose width is set by a parameter. A single-cycle synchronous register bus reaches it. Software can write the output latch in one piece. It can also use three write-only alias registers that drive chosen output bits high, drive them low or flip them, all within one bus access. No read-modify-write sequence is needed, so two software contexts that share the port cannot overwrite each other's bits.

A direction register sets which pins are driven: each bit drives one output enable. Pin inputs can change at any moment. Each one passes through a two-stage flip-flop synchroniser before software can read it from a read-only input register. An access that falls outside the six defined word offsets, or that is not word aligned, completes with an error flag and changes nothing.

Offsets decoded (byte addresses, word aligned): 0x00 output latch, 0x04 set alias, 0x08 clear alias, 0x0C toggle alias, 0x10 synchronised input, 0x14 direction.

Top module: `gpio_atomic_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `pin_out` and `pin_oe` are all zeros. A read of offset 0x00 or 0x14 returns 0 until written.
- R2: A write to offset 0x00 replaces the output latch with `bus_wdata` from the next rising edge. A read of 0x00 returns the latch value.
- R3: A write to offset 0x04 sets to 1 every output bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 forces to 0 every output bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every output bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R6: A read of offset 0x04, 0x08 or 0x0C returns all zeros.
- R7: A read of offset 0x10 returns the pin inputs as they were two rising edges earlier: a change set up before edge k is read after edge k+1 and not after edge k. A write to 0x10 raises no error and changes neither the output latch nor the direction register.
- R8: Offset 0x14 is a readable and writable direction register, where 1 means output. `pin_oe` equals it at all times.
- R9: An access to an offset above 0x14, or to an address whose two low bits are not 00, sets `bus_error` together with `bus_ready`. It returns `bus_rdata` 0 and leaves `pin_out` and `pin_oe` unchanged.
- R10: `bus_ready` is high in exactly the cycles where `bus_valid` is high. `bus_error` is never high without `bus_valid`.
- R11: `pin_out` changes only at a rising clock edge that follows a cycle with an error-free write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access completes this cycle |
| bus_error | output | 1 | Access hit no register or was misaligned |
| pin_in | input | W | Asynchronous pin inputs |
| pin_out | output | W | Output latch driven to the pins |
| pin_oe | output | W | Per-pin output enable |

## Verification
The checker watches several rules on every cycle: ready following the strobe, errors never changing state, set, clear and toggle effects on the bits they select, zero reads from the alias offsets, and the output and enable pins changing only after a qualifying write. Only the bench scenarios show the full register model under a random mix of accesses. The same holds for the exact two-edge latency of the input path, and for the rule that a write to the input offset is harmless.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam logic [31:0] OFF_LATCH = 32'h00;
    localparam logic [31:0] OFF_SET   = 32'h04;
    localparam logic [31:0] OFF_CLR   = 32'h08;
    localparam logic [31:0] OFF_TGL   = 32'h0C;
    localparam logic [31:0] OFF_PINS  = 32'h10;
    localparam logic [31:0] OFF_DIR   = 32'h14;

    typedef enum logic [2:0] {
        SEL_LATCH,
        SEL_SET,
        SEL_CLR,
        SEL_TGL,
        SEL_PINS,
        SEL_DIR,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     err;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    function automatic reg_sel_e addr_to_sel(input logic [31:0] addr);
        reg_sel_e s;
        if (addr[1:0] != 2'b00) begin
            s = SEL_NONE;
        end else begin
            case (addr)
                OFF_LATCH: s = SEL_LATCH;
                OFF_SET:   s = SEL_SET;
                OFF_CLR:   s = SEL_CLR;
                OFF_TGL:   s = SEL_TGL;
                OFF_PINS:  s = SEL_PINS;
                OFF_DIR:   s = SEL_DIR;
                default:   s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_pkg::*;
(
    input  logic        valid,
    input  logic        write,
    input  logic [31:0] addr,
    output bus_op_t     op
);
    reg_sel_e sel;

    always_comb begin
        sel     = addr_to_sel(addr);
        op.sel  = sel;
        op.err  = valid && (sel == SEL_NONE);
        op.hit  = valid && (sel != SEL_NONE);
        op.wr   = valid && write && (sel != SEL_NONE);
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= '0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_op_t      op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    logic [W-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        if (op.wr) begin
            case (op.sel)
                SEL_LATCH: latch_d = wdata;
                SEL_SET:   latch_d = latch_q | wdata;
                SEL_CLR:   latch_d = latch_q & ~wdata;
                SEL_TGL:   latch_d = latch_q ^ wdata;
                default:   latch_d = latch_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            latch_q <= latch_d;
            if (op.wr && op.sel == SEL_DIR) dir_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
    import gpio_pkg::*;
#(
    parameter int unsigned W           = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_valid,
    input  logic         bus_write,
    input  logic [31:0]  bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         bus_ready,
    output logic         bus_error,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    bus_op_t      op;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pins_sync;

    gpio_bus_decode u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .op    (op)
    );

    gpio_ctrl_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.hit && !bus_write) begin
            case (op.sel)
                SEL_LATCH: bus_rdata = latch_q;
                SEL_PINS:  bus_rdata = pins_sync;
                SEL_DIR:   bus_rdata = dir_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign bus_ready = bus_valid;
    assign bus_error = op.err;
    assign pin_out   = latch_q;
    assign pin_oe    = dir_q;
endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_valid,
    input logic         bus_write,
    input logic [31:0]  bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic         bus_ready,
    input logic         bus_error,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe
);
    logic wr_ok;
    assign wr_ok = bus_valid && bus_write && !bus_error;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0));

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && bus_addr == 32'h04) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && bus_addr == 32'h08) |=> ((pin_out & $past(bus_wdata)) == '0));

    assert_toggle_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && bus_addr == 32'h0C) |=> (pin_out == ($past(pin_out) ^ $past(bus_wdata))));

    assert_alias_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write &&
         (bus_addr == 32'h04 || bus_addr == 32'h08 || bus_addr == 32'h0C)) |-> (bus_rdata == '0));

    assert_oe_only_after_dir_write_R8: assert property (@(posedge clk) disable iff (rst)
        (pin_oe != $past(pin_oe)) |-> $past(wr_ok && bus_addr == 32'h14));

    assert_error_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_error) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_error_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_error) |-> (bus_rdata == '0));

    assert_ready_tracks_valid_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_ready == bus_valid) && !(bus_error && !bus_valid));

    assert_out_changes_after_write_R11: assert property (@(posedge clk) disable iff (rst)
        (pin_out != $past(pin_out)) |-> $past(wr_ok));
endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(.W(W)) u_chk (.*);

// File: tb/gpio_atomic_port_bench.sv
module gpio_atomic_port_bench;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [31:0]  bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         bus_ready;
    logic         bus_error;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_latch = '0;
    logic [W-1:0] m_dir   = '0;
    logic [W-1:0] m_pins  = '0;

    always #5 clk = ~clk;

    gpio_atomic_port #(.W(W)) u_gpio_atomic_port (.*);

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_valid_off(input logic [31:0] a);
        return (a[1:0] == 2'b00) && (a <= 32'h14);
    endfunction

    function automatic logic [W-1:0] model_read(input logic [31:0] a);
        case (a)
            32'h00:  return m_latch;
            32'h10:  return m_pins;
            32'h14:  return m_dir;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] model_write(input logic [31:0] a, input logic [W-1:0] d,
                                                 input logic [W-1:0] cur);
        case (a)
            32'h00:  return d;
            32'h04:  return cur | d;
            32'h08:  return cur & ~d;
            32'h0C:  return cur ^ d;
            default: return cur;
        endcase
    endfunction

    // one access: drive after falling edge, sample response, commit at rising edge
    task automatic access(input bit wr, input logic [31:0] a, input logic [W-1:0] d,
                          input string req);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = a;
        bus_wdata = d;
        #1;
        check({req, " R10 ready"}, W'(bus_ready), W'(1));
        check({req, " R9 error flag"}, W'(bus_error), W'(!is_valid_off(a)));
        if (!wr) check({req, " read data"}, bus_rdata, is_valid_off(a) ? model_read(a) : '0);
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        if (wr && is_valid_off(a)) begin
            m_latch = model_write(a, d, m_latch);
            if (a == 32'h14) m_dir = d;
        end
        check({req, " R11 pin_out"}, pin_out, m_latch);
        check({req, " R8 pin_oe"}, pin_oe, m_dir);
    endtask

    task automatic set_pins(input logic [W-1:0] v);
        @(negedge clk);
        #2 pin_in = v;
        repeat (3) @(posedge clk);
        m_pins = v;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pin_out", pin_out, '0);
        check("R1 reset pin_oe", pin_oe, '0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 idle ready", W'(bus_ready), W'(0));
        check("R10 idle error", W'(bus_error), W'(0));
        access(1'b0, 32'h00, '0, "R1 latch read");
        access(1'b0, 32'h14, '0, "R1 dir read");

        access(1'b1, 32'h00, 32'hA5A5_0F0F, "R2 write latch");
        access(1'b0, 32'h00, '0, "R2 read latch");
        access(1'b1, 32'h04, 32'h0000_F0F0, "R3 set");
        access(1'b1, 32'h08, 32'hA000_0001, "R4 clear");
        access(1'b1, 32'h0C, 32'hFFFF_0000, "R5 toggle");
        access(1'b1, 32'h04, 32'h0000_0000, "R3 set zero mask");
        access(1'b0, 32'h04, '0, "R6 set read");
        access(1'b0, 32'h08, '0, "R6 clear read");
        access(1'b0, 32'h0C, '0, "R6 toggle read");
        access(1'b1, 32'h14, 32'h1234_5678, "R8 dir write");
        access(1'b0, 32'h14, '0, "R8 dir read");
        access(1'b1, 32'h18, 32'hFFFF_FFFF, "R9 beyond map");
        access(1'b1, 32'h05, 32'hFFFF_FFFF, "R9 misaligned");
        access(1'b0, 32'h8000_0000, '0, "R9 high read");
        access(1'b1, 32'h10, 32'hDEAD_BEEF, "R7 write to input ignored");

        // input latency: change before edge k, visible only after edge k+1
        @(negedge clk);
        #2 pin_in = 32'hCAFE_1234;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 32'h10;
        #1 check("R7 one edge old value", bus_rdata, m_pins);
        @(negedge clk);
        #1 check("R7 two edges new value", bus_rdata, 32'hCAFE_1234);
        bus_valid = 1'b0;
        m_pins = 32'hCAFE_1234;

        for (int i = 0; i < 600; i++) begin
            int unsigned pick;
            logic [31:0] a;
            pick = $urandom % 10;
            if (pick < 6)       a = 32'(pick * 4);
            else if (pick == 6) a = 32'h18 + 32'(($urandom % 256) * 4);
            else if (pick == 7) a = {($urandom % 5) * 4}[31:0] | 32'(1 + $urandom % 3);
            else                a = 32'(($urandom % 4) * 4);
            if (i % 97 == 0) set_pins($urandom);
            access(($urandom % 2) == 1, a, $urandom, "random R2 R3 R4 R5 R7 R9");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule